// File: doc/BRIEF.md
# SDRAM Power-Up and Auto-Refresh Sequencer

This block drives the command pins of a two-bank-select SDRAM array from reset until the array is usable, and then keeps the array refreshed. After a programmable power-up wait it precharges every bank and issues two auto-refresh commands. It then loads the mode register with a word built from parameters. Every command is followed by the minimum number of idle clocks that the array needs. Two clocks after the mode register load it raises `init_done`, and from then on a user controller may open rows.

Once initialised, a free-running interval counter expires every `REF_INTERVAL` clocks. On expiry the sequencer raises `ref_req` towards the command-bus arbiter and holds it until `ref_gnt` is seen. It then issues a precharge-all and an auto-refresh, and stays on the bus until the refresh cycle time has passed. The arbiter must keep `ref_gnt` high until then. The grant may not come before a second expiry. In that case the refresh period has been overrun: the sequencer raises `ref_overrun` and, at the next grant, issues two auto-refresh commands back to back.

The controller is a single state machine. States: PWRUP, INIT_PRE, INIT_TRP, INIT_AR, INIT_TRFC, INIT_MRS, INIT_TMRD, IDLE, REQ, REF_PRE, REF_TRP, REF_AR, REF_TRFC. Transitions:
- PWRUP→INIT_PRE when the power-up wait ends.
- INIT_PRE→INIT_TRP, and INIT_TRP→INIT_AR when the precharge gap ends.
- INIT_AR→INIT_TRFC. INIT_TRFC→INIT_AR while refreshes remain, otherwise INIT_TRFC→INIT_MRS.
- INIT_MRS→INIT_TMRD, and INIT_TMRD→IDLE after the mode-load gap.
- IDLE→REQ when the interval has expired.
- REQ→REF_PRE on grant.
- REF_PRE→REF_TRP, REF_TRP→REF_AR, REF_AR→REF_TRFC.
- REF_TRFC→REF_AR while a second refresh is owed, otherwise REF_TRFC→IDLE.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is applied and for `PWRUP_CYC` cycles after its release, the pins carry no-operation (cs,ras,cas,we = L,H,H,H) with address and bank zero. During this time `init_done`, `ref_req` and `ref_overrun` are low.
- R2: Start-up issues exactly precharge, auto-refresh, auto-refresh, mode load, in that order. The gap to the next command is `T_RP` cycles after the precharge, `T_RFC` cycles after each auto-refresh and `T_MRD` cycles after the mode load. No-operation is driven in every cycle between commands. The encodings are: auto-refresh L,L,L,H; precharge L,L,H,L; mode load L,L,L,L.
- R3: Every precharge drives address bit 10 high, to select all banks, with the other address bits and the bank lines at zero.
- R4: The mode load drives the bank lines at zero and places the mode word on the address. The fields are: bits 2:0 burst length code, bit 3 interleaved burst, bits 6:4 CAS latency, bit 9 single-location writes. Bits 8:7 and 11:10 are zero. `init_done` rises `T_MRD` cycles after the mode load and never falls again.
- R5: The interval counter starts when `init_done` rises and expires every `REF_INTERVAL` cycles. The expiry cycle does not move with grant latency. `ref_req` rises the cycle after an expiry seen in IDLE, or the cycle after a refresh sequence ends if an expiry happened during it.
- R6: `ref_req` stays high until `ref_gnt` is sampled high. In the next cycle `ref_req` is low and a precharge-all is driven. An auto-refresh follows `T_RP` cycles later. IDLE is reached `T_RFC` cycles after the last auto-refresh.
- R7: `ref_gnt` has no effect while no request is pending: the pins stay at no-operation.
- R8: `ref_overrun` rises the cycle after a second interval expiry that occurs while the previous request is still ungranted. A grant that arrives before that expiry leaves it low.
- R9: At a grant with `ref_overrun` high, the precharge is followed by two auto-refresh commands `T_RFC` apart. `ref_overrun` falls when IDLE is re-entered after the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Command bus granted by arbiter, held until refresh completes |
| ref_req | output | 1 | Refresh needs the command bus |
| init_done | output | 1 | Start-up complete, row activates allowed |
| ref_overrun | output | 1 | Refresh period exceeded, wake-up pair pending |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines (bit 10 = all-bank select) |
| sd_ba | output | BA_W | Bank select lines |

## Verification
The bound checker watches, every cycle, the handshake: the request is held while ungranted and dropped on the grant, when the precharge starts. It also checks that every precharge selects all banks, that the mode word's reserved fields are zero, that `init_done` never falls, that no command leaves the block without the grant after start-up, that a command is always followed by a no-operation, and that the overrun flag only rises during a wait. The command order and exact gap lengths, the interval period and its independence from grant latency, the overrun threshold, and the double refresh with its flag clearing depend on long windows. These are shown only by the bench's queue model, which is compared on every clock across scenarios with prompt, late and very late grants and a stray grant pulse.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_INIT_PRE,
        ST_INIT_TRP,
        ST_INIT_AR,
        ST_INIT_TRFC,
        ST_INIT_MRS,
        ST_INIT_TMRD,
        ST_IDLE,
        ST_REQ,
        ST_REF_PRE,
        ST_REF_TRP,
        ST_REF_AR,
        ST_REF_TRFC
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = 4'b0111;
    localparam sdr_cmd_t CMD_PRE = 4'b0010;
    localparam sdr_cmd_t CMD_REF = 4'b0001;
    localparam sdr_cmd_t CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdr_gap_timer.sv
// Down-counter that measures the idle gap after a command.
// Loading value V keeps 'expired' low for V cycles.
module sdr_gap_timer #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdr_refresh_interval.sv
// Free-running refresh interval counter with due and overrun tracking.
module sdr_refresh_interval #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic accept,
    input  logic pair_done,
    output logic tick,
    output logic due,
    output logic overrun
);

    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RELOAD;
        end else if (!run || cnt == '0) begin
            cnt <= RELOAD;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            due <= 1'b0;
        end else if (tick) begin
            due <= 1'b1;
        end else if (accept) begin
            due <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (tick && due && !accept) begin
            overrun <= 1'b1;
        end else if (pair_done) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int          ADDR_W           = 12,
    parameter int          BA_W             = 2,
    parameter int          PWRUP_CYC        = 25000,
    parameter int          T_RP             = 3,
    parameter int          T_RFC            = 9,
    parameter int          T_MRD            = 2,
    parameter int          REF_INTERVAL     = 1953,
    parameter logic [2:0]  BURST_LEN_CODE   = 3'b010,
    parameter logic        BURST_INTERLEAVE = 1'b0,
    parameter logic [2:0]  CAS_LAT          = 3'd3,
    parameter logic        WRITE_SINGLE     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              init_done,
    output logic              ref_overrun,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);

    localparam int GAP_MAX  = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                             : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int WAIT_MAX = (PWRUP_CYC > GAP_MAX) ? PWRUP_CYC : GAP_MAX;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [WAIT_W-1:0] LD_RP  = WAIT_W'(T_RP - 2);
    localparam logic [WAIT_W-1:0] LD_RFC = WAIT_W'(T_RFC - 2);
    localparam logic [WAIT_W-1:0] LD_MRD = WAIT_W'(T_MRD - 2);
    localparam int ALL_BANK_BIT = 10;
    localparam logic [11:0] MODE_BITS = {2'b00, WRITE_SINGLE, 2'b00, CAS_LAT,
                                         BURST_INTERLEAVE, BURST_LEN_CODE};
    localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_BITS);

    seq_state_t  state, state_nx;
    sdr_cmd_t    cmd;
    logic        gap_load;
    logic [WAIT_W-1:0] gap_val;
    logic        gap_done;
    logic        tick, due;
    logic        accept;
    logic        pair_done;
    logic [1:0]  ar_left;
    logic        pair;

    // idle-gap timer; its reset value is the power-up wait
    sdr_gap_timer #(
        .W       (WAIT_W),
        .RST_VAL (PWRUP_CYC)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_done)
    );

    sdr_refresh_interval #(
        .INTERVAL (REF_INTERVAL)
    ) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (init_done),
        .accept    (accept),
        .pair_done (pair_done),
        .tick      (tick),
        .due       (due),
        .overrun   (ref_overrun)
    );

    assign accept    = (state == ST_REQ) && ref_gnt;
    assign pair_done = (state == ST_REF_TRFC) && gap_done && (ar_left == 2'd0) && pair;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PWRUP;
        end else begin
            state <= state_nx;
        end
    end

    // refresh-count bookkeeping for the start-up and wake-up pairs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_left <= 2'd0;
            pair    <= 1'b0;
        end else if (state == ST_INIT_PRE) begin
            ar_left <= 2'd2;
        end else if (accept) begin
            ar_left <= ref_overrun ? 2'd2 : 2'd1;
            pair    <= ref_overrun;
        end else if (state == ST_INIT_AR || state == ST_REF_AR) begin
            ar_left <= ar_left - 2'd1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP:     if (gap_done) state_nx = ST_INIT_PRE;
            ST_INIT_PRE:  state_nx = ST_INIT_TRP;
            ST_INIT_TRP:  if (gap_done) state_nx = ST_INIT_AR;
            ST_INIT_AR:   state_nx = ST_INIT_TRFC;
            ST_INIT_TRFC: if (gap_done) state_nx = (ar_left != 2'd0) ? ST_INIT_AR : ST_INIT_MRS;
            ST_INIT_MRS:  state_nx = ST_INIT_TMRD;
            ST_INIT_TMRD: if (gap_done) state_nx = ST_IDLE;
            ST_IDLE:      if (due || tick) state_nx = ST_REQ;
            ST_REQ:       if (ref_gnt) state_nx = ST_REF_PRE;
            ST_REF_PRE:   state_nx = ST_REF_TRP;
            ST_REF_TRP:   if (gap_done) state_nx = ST_REF_AR;
            ST_REF_AR:    state_nx = ST_REF_TRFC;
            ST_REF_TRFC:  if (gap_done) state_nx = (ar_left != 2'd0) ? ST_REF_AR : ST_IDLE;
            default:      state_nx = ST_PWRUP;
        endcase
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        sd_ba     = '0;
        gap_load  = 1'b0;
        gap_val   = '0;
        unique case (state)
            ST_INIT_PRE, ST_REF_PRE: begin
                cmd                   = CMD_PRE;
                sd_addr[ALL_BANK_BIT] = 1'b1;
                gap_load              = 1'b1;
                gap_val               = LD_RP;
            end
            ST_INIT_AR, ST_REF_AR: begin
                cmd      = CMD_REF;
                gap_load = 1'b1;
                gap_val  = LD_RFC;
            end
            ST_INIT_MRS: begin
                cmd      = CMD_MRS;
                sd_addr  = MODE_WORD;
                gap_load = 1'b1;
                gap_val  = LD_MRD;
            end
            ST_PWRUP, ST_INIT_TRP, ST_INIT_TRFC, ST_INIT_TMRD,
            ST_IDLE, ST_REQ, ST_REF_TRP, ST_REF_TRFC: begin
                cmd = CMD_NOP;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n   = cmd.cs_n;
    assign sd_ras_n  = cmd.ras_n;
    assign sd_cas_n  = cmd.cas_n;
    assign sd_we_n   = cmd.we_n;
    assign ref_req   = (state == ST_REQ);
    assign init_done = (state == ST_IDLE) || (state == ST_REQ) || (state == ST_REF_PRE) ||
                       (state == ST_REF_TRP) || (state == ST_REF_AR) || (state == ST_REF_TRFC);

endmodule

// File: rtl/sdram_init_refresh_seq_chk.sv
module sdram_init_refresh_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              init_done,
    input logic              ref_overrun,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba
);

    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_gnt |=> ref_req);                                        // R6
    AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> !ref_req && pins == 4'b0010);                     // R6
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0010 |-> sd_addr[10] && sd_ba == '0);                         // R3
    AST_MODE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0000 |-> sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00 && sd_ba == '0); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);                                                // R4
    AST_BUS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && pins != 4'b0111 |-> ref_gnt);                               // R7
    AST_GAP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        pins != 4'b0111 |=> pins == 4'b0111);                                    // R2
    AST_OVERRUN_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_overrun) |-> ref_req);                                         // R8

endmodule

bind sdram_init_refresh_seq sdram_init_refresh_seq_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_gnt     (ref_gnt),
    .ref_req     (ref_req),
    .init_done   (init_done),
    .ref_overrun (ref_overrun),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_addr     (sd_addr),
    .sd_ba       (sd_ba)
);

// File: tb/sdram_init_refresh_seq_test.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq_test;

    localparam int PW   = 10;
    localparam int TRP  = 3;
    localparam int TRFC = 9;
    localparam int TMRD = 2;
    localparam int IV   = 60;
    localparam int J    = PW + TRP + 2*TRFC + TMRD;   // first sample with init_done
    localparam int NSAMP = 600;
    // kinds: 0 nop, 1 precharge, 2 auto-refresh, 3 mode load
    localparam logic [3:0] ENC [4] = '{4'b0111, 4'b0010, 4'b0001, 4'b0000};
    localparam logic [11:0] MODE_EXP = 12'h22B;  // BL8 code 011, interleaved, CL2, single writes

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_gnt;
    logic        ref_req, init_done, ref_overrun;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0]  ba;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdram_init_refresh_seq #(
        .ADDR_W(12), .BA_W(2), .PWRUP_CYC(PW), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .REF_INTERVAL(IV), .BURST_LEN_CODE(3'b011), .BURST_INTERLEAVE(1'b1),
        .CAS_LAT(3'd2), .WRITE_SINGLE(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .init_done(init_done), .ref_overrun(ref_overrun),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_addr(addr), .sd_ba(ba)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] addr_of(input int kind);
        if (kind == 1) return 12'h400;
        if (kind == 3) return MODE_EXP;
        return 12'h000;
    endfunction

    function automatic int grant_delay(input int n);
        case (n)
            0: return 3;
            1: return 0;
            2: return IV + 10;   // overrun case
            3: return IV - 5;    // late but within one extra interval
            default: return 2;
        endcase
    endfunction

    int q[$];

    task automatic push_gap(input int kind, input int gap);
        q.push_back(kind);
        for (int i = 1; i < gap; i++) q.push_back(0);
    endtask

    initial begin
        bit m_req, m_due, m_over, m_pair;
        int ref_no, wcnt, idle_cnt, ar_exp, ar_seen, ovr_seen;
        m_req = 0; m_due = 0; m_over = 0; m_pair = 0;
        ref_no = 0; wcnt = 0; idle_cnt = 0; ar_exp = 0; ar_seen = 0; ovr_seen = 0;
        ref_gnt = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(!init_done && !ref_req && !ref_overrun, "R1", "reset flags",
            {init_done, ref_req, ref_overrun}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < PW; i++) q.push_back(0);
        push_gap(1, TRP);
        push_gap(2, TRFC);
        push_gap(2, TRFC);
        push_gap(3, TMRD);

        for (int k = 0; k < NSAMP; k++) begin
            bit in_seq, done, tick, idle, seq_last, accept;
            bit n_due, n_over, n_req;
            int kind;
            string tag;
            @(negedge clk);
            in_seq = (q.size() > 0);
            kind = in_seq ? q.pop_front() : 0;
            done = (k >= J);
            tick = done && (((k - J) % IV) == IV - 1);
            idle = done && !m_req && !in_seq;
            seq_last = in_seq && (q.size() == 0) && done;

            if (k < PW)          tag = "R1";
            else if (!done)      tag = (kind == 1) ? "R3" : (kind == 3) ? "R4" : "R2";
            else if (idle)       tag = ref_gnt ? "R7" : "R5";
            else if (m_pair)     tag = "R9";
            else                 tag = (kind == 1) ? "R3" : "R6";

            chk({cs_n, ras_n, cas_n, we_n} == ENC[kind], tag, "command pins",
                {cs_n, ras_n, cas_n, we_n}, ENC[kind]);
            chk(addr == addr_of(kind), tag, "address", addr, addr_of(kind));
            chk(ba == 2'b00, tag, "bank", ba, 0);
            chk(init_done == done, "R4", "init_done", init_done, done);
            chk(ref_req == m_req, "R5", "ref_req", ref_req, m_req);
            chk(ref_overrun == m_over, "R8", "ref_overrun", ref_overrun, m_over);
            if (done && {cs_n, ras_n, cas_n, we_n} == 4'b0001) ar_seen++;
            if (ref_overrun) ovr_seen++;

            // arbiter behaviour
            if (m_req) begin
                if (wcnt >= grant_delay(ref_no)) ref_gnt = 1'b1;
                wcnt++;
            end
            if (seq_last) ref_gnt = 1'b0;
            if (ref_no == 2 && idle) begin
                idle_cnt++;
                ref_gnt = (idle_cnt >= 5 && idle_cnt < 8);   // stray grant, R7
            end

            accept = m_req && ref_gnt;
            if (accept) begin
                push_gap(1, TRP);
                push_gap(2, TRFC);
                ar_exp++;
                if (m_over) begin
                    push_gap(2, TRFC);
                    ar_exp++;
                end
                m_pair = m_over;
                ref_no++;
                wcnt = 0;
            end

            n_due  = tick ? 1'b1 : (accept ? 1'b0 : m_due);
            n_over = (tick && m_due && !accept) ? 1'b1 : ((seq_last && m_pair) ? 1'b0 : m_over);
            n_req  = (m_req && !accept) || (idle && (m_due || tick));
            if (seq_last && m_pair) m_pair = 0;
            m_due = n_due; m_over = n_over; m_req = n_req;
        end

        chk(ovr_seen > 0, "R8", "overrun observed", ovr_seen, 1);
        chk(ar_seen == ar_exp, "R9", "refresh command count", ar_seen, ar_exp);
        chk(ref_no >= 5, "R5", "refresh requests served", ref_no, 5);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule